// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a processor that spends a varying number of clock cycles on each instruction and reuses one ALU and one memory port across those cycles. It is a Moore state machine. Its inputs are the opcode and function fields of the held instruction and the register-equality flag from the datapath. Its outputs are every register load enable and every multiplexer select that the datapath needs. The only exception to pure Moore outputs is the program-counter enable in the branch state, which follows the equality flag. Loads take five cycles. Stores, immediate adds and register-register operations take four. Branches and jumps take three.

There are eleven states. S_FETCH reads the instruction and advances the PC by four. S_DECODE loads the operand registers and forms the branch target. From S_DECODE the machine goes to S_MEM_ADDR for loads, stores and immediate adds, to S_ALU_EXEC for register-register operations, to S_BRANCH for conditional branches, to S_JUMP for jumps, and back to S_FETCH for an unrecognised opcode or function code. From S_MEM_ADDR a load goes to S_MEM_READ and then S_LOAD_WB, a store goes to S_MEM_WRITE, and an immediate add goes to S_IMM_WB. S_ALU_EXEC goes to S_ALU_WB. Every final state (S_LOAD_WB, S_MEM_WRITE, S_IMM_WB, S_ALU_WB, S_BRANCH, S_JUMP) returns to S_FETCH. The instruction class is decoded in S_DECODE and held in a register for the rest of the instruction.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset, applied at any point, places the machine in fetch. In the fetch cycle mem_rd, ir_we and pc_we are 1, addr_sel is 0 (the PC), alu_a_sel is 0 (the PC), alu_b_sel is 1 (constant four) and pc_src is 0 (the ALU result).
- R2: The cycle after every fetch is decode. In decode ab_we and aluout_we are 1, alu_a_sel is 0 and alu_b_sel is 3 (shifted immediate), and no PC, memory or register-file write takes place.
- R3: A load (opcode 0x23) takes 5 cycles. In cycle 4 mem_rd and mdr_we are 1 with addr_sel 1 (the ALUOut address). In cycle 5 rf_we is 1 with rf_dst_sel 0 (rt) and rf_src_sel 1 (memory data).
- R4: A store (opcode 0x2B) takes 4 cycles. mem_we is 1 for exactly one cycle, cycle 4, with addr_sel 1. rf_we is never asserted.
- R5: An immediate add (opcode 0x08) takes 4 cycles. Cycle 3 computes with alu_a_sel 1 and alu_b_sel 2 (sign-extended immediate). Cycle 4 asserts rf_we with rf_dst_sel 0 and rf_src_sel 0 (ALUOut).
- R6: Register-register instructions (opcode 0x00 with function 0x20 for add or 0x24 for and) take 4 cycles. Cycle 3 asserts aluout_we with alu_a_sel 1, alu_b_sel 0 and alu_op 0 for add or 1 for and. Cycle 4 asserts rf_we with rf_dst_sel 1 (rd) and rf_src_sel 0.
- R7: A branch takes 3 cycles and drives pc_src 1 (target in ALUOut) in cycle 3. For branch-if-equal (opcode 0x04), pc_we in that cycle equals a_eq_b. For branch-if-not-equal (opcode 0x05), it equals the inverse of a_eq_b.
- R8: A jump (opcode 0x02) takes 3 cycles, and cycle 3 asserts pc_we with pc_src 2 (concatenated jump target).
- R9: Any other opcode, and opcode 0x00 with any other function code, returns to fetch after decode (2 cycles). No register-file or memory write takes place and pc_we is asserted only in the fetch cycle.
- R10: pc_we is asserted only in fetch, branch and jump cycles. At most one of ir_we, mdr_we, mem_we and rf_we is 1 in any cycle, and mem_rd and mem_we are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OP_W | Opcode field of the instruction register |
| funct | input | FN_W | Function field of the instruction register |
| a_eq_b | input | 1 | Operand registers A and B are equal |
| pc_we | output | 1 | PC load enable |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALUOut, 2 jump target |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| mem_rd | output | 1 | Memory read |
| mem_we | output | 1 | Memory write of B |
| ir_we | output | 1 | Instruction register load |
| mdr_we | output | 1 | Memory data register load |
| ab_we | output | 1 | Operand registers A and B load |
| aluout_we | output | 1 | ALUOut register load |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 0 B, 1 four, 2 immediate, 3 immediate shifted by two |
| alu_op | output | 2 | ALU function: 0 add, 1 and, 2 subtract |
| rf_we | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Write register: 0 rt, 1 rd |
| rf_src_sel | output | 1 | Write data: 0 ALUOut, 1 memory data |

## Verification
The bench builds the block with its default 6-bit opcode and function widths and the default opcode assignments. At these sizes every one of the 64 opcodes can be run with both values of the equality flag, and every one of the 64 function codes can be run under the register-register opcode. This covers every decode path, including every unknown encoding. For each run the bench records the outputs of every cycle from one fetch to the next. It then compares the cycle count, the number of PC, register-file and memory writes, and the selects on the cycles that matter against values it works out from the opcode. It also asserts reset in the middle of a load.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [3:0] {
        S_FETCH,
        S_DECODE,
        S_MEM_ADDR,
        S_MEM_READ,
        S_LOAD_WB,
        S_MEM_WRITE,
        S_ALU_EXEC,
        S_ALU_WB,
        S_IMM_WB,
        S_BRANCH,
        S_JUMP
    } state_e;

    typedef enum logic [3:0] {
        C_LOAD,
        C_STORE,
        C_ADDI,
        C_ADD,
        C_AND,
        C_BEQ,
        C_BNE,
        C_JUMP,
        C_BAD
    } cls_e;

    localparam logic [1:0] ALU_ADD = 2'd0;
    localparam logic [1:0] ALU_AND = 2'd1;
    localparam logic [1:0] ALU_SUB = 2'd2;

    localparam logic [1:0] BSRC_REG    = 2'd0;
    localparam logic [1:0] BSRC_FOUR   = 2'd1;
    localparam logic [1:0] BSRC_IMM    = 2'd2;
    localparam logic [1:0] BSRC_IMM_SH = 2'd3;

    localparam logic [1:0] PCSRC_ALU = 2'd0;
    localparam logic [1:0] PCSRC_TGT = 2'd1;
    localparam logic [1:0] PCSRC_JMP = 2'd2;

    typedef struct packed {
        logic       pc_we;
        logic [1:0] pc_src;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_we;
        logic       ir_we;
        logic       mdr_we;
        logic       ab_we;
        logic       aluout_we;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic       rf_we;
        logic       rf_dst_sel;
        logic       rf_src_sel;
    } ctrl_t;

endpackage

// File: rtl/mcc_classify.sv
module mcc_classify
    import mcc_pkg::*;
#(
    parameter int unsigned      OP_W     = 6,
    parameter int unsigned      FN_W     = 6,
    parameter logic [OP_W-1:0]  OP_LOAD  = 'h23,
    parameter logic [OP_W-1:0]  OP_STORE = 'h2B,
    parameter logic [OP_W-1:0]  OP_ADDI  = 'h08,
    parameter logic [OP_W-1:0]  OP_REG   = 'h00,
    parameter logic [OP_W-1:0]  OP_BEQ   = 'h04,
    parameter logic [OP_W-1:0]  OP_BNE   = 'h05,
    parameter logic [OP_W-1:0]  OP_JUMP  = 'h02,
    parameter logic [FN_W-1:0]  FN_ADD   = 'h20,
    parameter logic [FN_W-1:0]  FN_AND   = 'h24
) (
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output cls_e            cls
);

    always_comb begin
        cls = C_BAD;
        if (opcode == OP_LOAD) begin
            cls = C_LOAD;
        end else if (opcode == OP_STORE) begin
            cls = C_STORE;
        end else if (opcode == OP_ADDI) begin
            cls = C_ADDI;
        end else if (opcode == OP_BEQ) begin
            cls = C_BEQ;
        end else if (opcode == OP_BNE) begin
            cls = C_BNE;
        end else if (opcode == OP_JUMP) begin
            cls = C_JUMP;
        end else if (opcode == OP_REG) begin
            if (funct == FN_ADD) begin
                cls = C_ADD;
            end else if (funct == FN_AND) begin
                cls = C_AND;
            end
        end
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e state,
    input  cls_e   cls_live,
    input  cls_e   cls_held,
    output state_e state_nx
);

    always_comb begin
        state_nx = S_FETCH;
        unique case (state)
            S_FETCH:    state_nx = S_DECODE;
            S_DECODE: begin
                unique case (cls_live)
                    C_LOAD, C_STORE, C_ADDI: state_nx = S_MEM_ADDR;
                    C_ADD, C_AND:            state_nx = S_ALU_EXEC;
                    C_BEQ, C_BNE:            state_nx = S_BRANCH;
                    C_JUMP:                  state_nx = S_JUMP;
                    default:                 state_nx = S_FETCH;
                endcase
            end
            S_MEM_ADDR: begin
                unique case (cls_held)
                    C_LOAD:  state_nx = S_MEM_READ;
                    C_STORE: state_nx = S_MEM_WRITE;
                    C_ADDI:  state_nx = S_IMM_WB;
                    default: state_nx = S_FETCH;
                endcase
            end
            S_MEM_READ: state_nx = S_LOAD_WB;
            S_ALU_EXEC: state_nx = S_ALU_WB;
            S_LOAD_WB, S_MEM_WRITE, S_ALU_WB, S_IMM_WB,
            S_BRANCH, S_JUMP: state_nx = S_FETCH;
            default:    state_nx = S_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_outputs.sv
module mcc_outputs
    import mcc_pkg::*;
(
    input  state_e state,
    input  cls_e   cls_held,
    input  logic   a_eq_b,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (state)
            S_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.addr_sel  = 1'b0;
                ctrl.ir_we     = 1'b1;
                ctrl.alu_a_sel = 1'b0;
                ctrl.alu_b_sel = BSRC_FOUR;
                ctrl.alu_op    = ALU_ADD;
                ctrl.pc_src    = PCSRC_ALU;
                ctrl.pc_we     = 1'b1;
            end
            S_DECODE: begin
                ctrl.ab_we     = 1'b1;
                ctrl.aluout_we = 1'b1;
                ctrl.alu_a_sel = 1'b0;
                ctrl.alu_b_sel = BSRC_IMM_SH;
                ctrl.alu_op    = ALU_ADD;
            end
            S_MEM_ADDR: begin
                ctrl.aluout_we = 1'b1;
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSRC_IMM;
                ctrl.alu_op    = ALU_ADD;
            end
            S_MEM_READ: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
                ctrl.mdr_we   = 1'b1;
            end
            S_LOAD_WB: begin
                ctrl.rf_we      = 1'b1;
                ctrl.rf_dst_sel = 1'b0;
                ctrl.rf_src_sel = 1'b1;
            end
            S_MEM_WRITE: begin
                ctrl.mem_we   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            S_ALU_EXEC: begin
                ctrl.aluout_we = 1'b1;
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSRC_REG;
                ctrl.alu_op    = (cls_held == C_AND) ? ALU_AND : ALU_ADD;
            end
            S_ALU_WB: begin
                ctrl.rf_we      = 1'b1;
                ctrl.rf_dst_sel = 1'b1;
                ctrl.rf_src_sel = 1'b0;
            end
            S_IMM_WB: begin
                ctrl.rf_we      = 1'b1;
                ctrl.rf_dst_sel = 1'b0;
                ctrl.rf_src_sel = 1'b0;
            end
            S_BRANCH: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSRC_REG;
                ctrl.alu_op    = ALU_SUB;
                ctrl.pc_src    = PCSRC_TGT;
                ctrl.pc_we     = (cls_held == C_BNE) ? ~a_eq_b : a_eq_b;
            end
            S_JUMP: begin
                ctrl.pc_src = PCSRC_JMP;
                ctrl.pc_we  = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int unsigned OP_W = 6,
    parameter int unsigned FN_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    input  logic            a_eq_b,
    output logic            pc_we,
    output logic [1:0]      pc_src,
    output logic            addr_sel,
    output logic            mem_rd,
    output logic            mem_we,
    output logic            ir_we,
    output logic            mdr_we,
    output logic            ab_we,
    output logic            aluout_we,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op,
    output logic            rf_we,
    output logic            rf_dst_sel,
    output logic            rf_src_sel
);

    state_e state_q;
    state_e state_nx;
    cls_e   cls_live;
    cls_e   cls_q;
    ctrl_t  ctrl;
    logic   rst_q;

    mcc_classify #(
        .OP_W (OP_W),
        .FN_W (FN_W)
    ) u_classify (
        .opcode (opcode),
        .funct  (funct),
        .cls    (cls_live)
    );

    mcc_next_state u_next (
        .state    (state_q),
        .cls_live (cls_live),
        .cls_held (cls_q),
        .state_nx (state_nx)
    );

    // State register and instruction class held from decode onwards
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FETCH;
            cls_q   <= C_BAD;
        end else begin
            state_q <= state_nx;
            if (state_q == S_DECODE) begin
                cls_q <= cls_live;
            end
        end
        rst_q <= rst;
    end

    mcc_outputs u_outputs (
        .state    (state_q),
        .cls_held (cls_q),
        .a_eq_b   (a_eq_b),
        .ctrl     (ctrl)
    );

    assign pc_we      = ctrl.pc_we;
    assign pc_src     = ctrl.pc_src;
    assign addr_sel   = ctrl.addr_sel;
    assign mem_rd     = ctrl.mem_rd;
    assign mem_we     = ctrl.mem_we;
    assign ir_we      = ctrl.ir_we;
    assign mdr_we     = ctrl.mdr_we;
    assign ab_we      = ctrl.ab_we;
    assign aluout_we  = ctrl.aluout_we;
    assign alu_a_sel  = ctrl.alu_a_sel;
    assign alu_b_sel  = ctrl.alu_b_sel;
    assign alu_op     = ctrl.alu_op;
    assign rf_we      = ctrl.rf_we;
    assign rf_dst_sel = ctrl.rf_dst_sel;
    assign rf_src_sel = ctrl.rf_src_sel;

    // R1: the first cycle after reset is fetch
    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            p_reset_to_fetch_r1: assert (state_q == S_FETCH && ir_we && pc_we);
        end
    end

    p_decode_after_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        state_q == S_FETCH |=> state_q == S_DECODE);

    p_load_writeback_r3: assert property (@(posedge clk) disable iff (rst)
        state_q == S_MEM_READ |=> (rf_we && rf_src_sel));

    p_beq_follows_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_BRANCH && cls_q == C_BEQ) |-> pc_we == a_eq_b);

    p_bne_follows_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_BRANCH && cls_q == C_BNE) |-> pc_we == !a_eq_b);

    p_unknown_returns_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DECODE && cls_live == C_BAD) |=> state_q == S_FETCH);

    p_pc_we_states_r10: assert property (@(posedge clk) disable iff (rst)
        pc_we |-> (state_q == S_FETCH || state_q == S_BRANCH || state_q == S_JUMP));

    p_single_writer_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_we, mdr_we, mem_we, rf_we}) && !(mem_rd && mem_we));

endmodule

// File: tb/mc_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] op  = '0;
    logic [5:0] fn  = '0;
    logic       eq  = 1'b0;

    logic       pc_we, addr_sel, mem_rd, mem_we, ir_we, mdr_we, ab_we, aluout_we;
    logic       alu_a_sel, rf_we, rf_dst_sel, rf_src_sel;
    logic [1:0] pc_src, alu_b_sel, alu_op;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    int s_pcwe[10], s_pcsrc[10], s_addr[10], s_mrd[10], s_mwe[10], s_mdr[10];
    int s_ao[10], s_asel[10], s_bsel[10], s_aop[10], s_rf[10], s_dst[10], s_src[10];
    int s_ab[10], s_excl[10];

    always #2 clk = ~clk;

    mc_ctrl_fsm u_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(op), .funct(fn), .a_eq_b(eq),
        .pc_we(pc_we), .pc_src(pc_src), .addr_sel(addr_sel), .mem_rd(mem_rd),
        .mem_we(mem_we), .ir_we(ir_we), .mdr_we(mdr_we), .ab_we(ab_we),
        .aluout_we(aluout_we), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .rf_we(rf_we), .rf_dst_sel(rf_dst_sel), .rf_src_sel(rf_src_sel)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic record(input int i);
        s_pcwe[i]  = int'(pc_we);
        s_pcsrc[i] = int'(pc_src);
        s_addr[i]  = int'(addr_sel);
        s_mrd[i]   = int'(mem_rd);
        s_mwe[i]   = int'(mem_we);
        s_mdr[i]   = int'(mdr_we);
        s_ab[i]    = int'(ab_we);
        s_ao[i]    = int'(aluout_we);
        s_asel[i]  = int'(alu_a_sel);
        s_bsel[i]  = int'(alu_b_sel);
        s_aop[i]   = int'(alu_op);
        s_rf[i]    = int'(rf_we);
        s_dst[i]   = int'(rf_dst_sel);
        s_src[i]   = int'(rf_src_sel);
        s_excl[i]  = ((int'(ir_we) + int'(mdr_we) + int'(mem_we) + int'(rf_we)) > 1 ||
                      (mem_rd && mem_we)) ? 1 : 0;
    endtask

    // Starts at a negedge in fetch; runs until the next fetch
    task automatic run_instr(input logic [5:0] o, input logic [5:0] f, input logic e);
        op = o; fn = f; eq = e; cyc = 0;
        do begin
            record(cyc);
            cyc++;
            @(negedge clk);
        end while (!ir_we && cyc < 10);
    endtask

    function automatic int sum(input int a[10], input int n);
        int t = 0;
        for (int i = 0; i < n && i < 10; i++) t += a[i];
        return t;
    endfunction

    task automatic check_instr(input logic [5:0] o, input logic [5:0] f, input logic e);
        bit is_ld  = (o == 6'h23);
        bit is_st  = (o == 6'h2B);
        bit is_ai  = (o == 6'h08);
        bit is_add = (o == 6'h00) && (f == 6'h20);
        bit is_and = (o == 6'h00) && (f == 6'h24);
        bit is_beq = (o == 6'h04);
        bit is_bne = (o == 6'h05);
        bit is_j   = (o == 6'h02);
        bit bad    = !(is_ld || is_st || is_ai || is_add || is_and || is_beq || is_bne || is_j);
        int exp_cyc, exp_pc, exp_rf;
        bit taken  = (is_beq && e) || (is_bne && !e);

        exp_cyc = is_ld ? 5 : (is_st || is_ai || is_add || is_and) ? 4 :
                  (is_beq || is_bne || is_j) ? 3 : 2;
        exp_pc  = 1 + (is_j ? 1 : 0) + (taken ? 1 : 0);
        exp_rf  = (is_ld || is_ai || is_add || is_and) ? 1 : 0;

        run_instr(o, f, e);

        chk("R2", "decode ab_we",   s_ab[1], 1);
        chk("R2", "decode b_sel",   s_bsel[1], 3);
        chk("R2", "decode writes",  s_pcwe[1] + s_rf[1] + s_mwe[1], 0);
        chk("R10", "exclusive writes", sum(s_excl, cyc), 0);
        chk("R10", "pc_we count",   sum(s_pcwe, cyc), exp_pc);
        chk("R10", "rf_we count",   sum(s_rf, cyc), exp_rf);
        chk("R10", "mem_we count",  sum(s_mwe, cyc), is_st ? 1 : 0);
        chk("R10", "mdr_we count",  sum(s_mdr, cyc), is_ld ? 1 : 0);

        if (is_ld) begin
            chk("R3", "cycles", cyc, exp_cyc);
            chk("R3", "read step", s_mrd[3] + s_addr[3] + s_mdr[3], 3);
            chk("R3", "wb rf_we", s_rf[4], 1);
            chk("R3", "wb dst/src", s_dst[4] * 2 + s_src[4], 1);
        end else if (is_st) begin
            chk("R4", "cycles", cyc, exp_cyc);
            chk("R4", "write step", s_mwe[3] + s_addr[3], 2);
        end else if (is_ai) begin
            chk("R5", "cycles", cyc, exp_cyc);
            chk("R5", "addr sel", s_asel[2] * 4 + s_bsel[2], 6);
            chk("R5", "wb", s_rf[3] * 4 + s_dst[3] * 2 + s_src[3], 4);
        end else if (is_add || is_and) begin
            chk("R6", "cycles", cyc, exp_cyc);
            chk("R6", "exec alu_op", s_aop[2], is_and ? 1 : 0);
            chk("R6", "exec sel", s_ao[2] * 8 + s_asel[2] * 4 + s_bsel[2], 12);
            chk("R6", "wb", s_rf[3] * 4 + s_dst[3] * 2 + s_src[3], 6);
        end else if (is_beq || is_bne) begin
            chk("R7", "cycles", cyc, exp_cyc);
            chk("R7", "pc_src", s_pcsrc[2], 1);
            chk("R7", "pc_we", s_pcwe[2], taken ? 1 : 0);
        end else if (is_j) begin
            chk("R8", "cycles", cyc, exp_cyc);
            chk("R8", "pc_src/pc_we", s_pcsrc[2] * 2 + s_pcwe[2], 5);
        end else if (bad) begin
            chk("R9", "cycles", cyc, exp_cyc);
            chk("R9", "writes", sum(s_rf, cyc) + sum(s_mwe, cyc), 0);
        end
    endtask

    task automatic check_fetch(input string tag);
        chk("R1", {tag, " ir/mem_rd/pc_we"}, int'(ir_we) + int'(mem_rd) + int'(pc_we), 3);
        chk("R1", {tag, " addr/a_sel"}, int'(addr_sel) + int'(alu_a_sel), 0);
        chk("R1", {tag, " b_sel"}, int'(alu_b_sel), 1);
        chk("R1", {tag, " pc_src"}, int'(pc_src), 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_fetch("after reset");

        for (int o = 0; o < 64; o++) begin
            for (int f = 0; f < ((o == 0) ? 64 : 1); f++) begin
                for (int e = 0; e < 2; e++) begin
                    check_instr(6'(o), 6'(f), 1'(e));
                end
            end
        end

        // R1: reset in the middle of a load
        op = 6'h23; fn = '0; eq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "mid-load mdr_we before reset", int'(mdr_we), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_fetch("mid-load reset");
        check_instr(6'h23, 6'h00, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule